// File: doc/BRIEF.md
# Block-Mode DMA Request Generator

This block drives the two DMA request lines of one serial channel when the channel moves data in whole blocks. It does not contain the FIFOs. It reads the receive FIFO fill count, the transmit FIFO free-space count, two programmed thresholds, a receive time-out pulse and a receive data-error flag. From these it produces an active-low receive request and an active-low transmit request.

Each request has block-transfer hysteresis. A request is raised when its threshold is met. The receive request is also raised on a time-out. Once raised, the request is held until the FIFO is completely drained (receive) or completely filled (transmit). Dropping back below the threshold does not release it. A flagged receive error also releases the receive request. The DMA controller therefore always moves a full block per grant. Both outputs come from flops. When a release condition and a raise condition are true in the same cycle, the release wins.

Top module: `dbh_dma_req`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it rises, both `rx_req_n` and `tx_req_n` are high (inactive).
- R2: When `rx_fill` is greater than or equal to `rx_trig`, with `rx_fill` nonzero and `rx_err` low, `rx_req_n` is low after the next rising clock edge. This includes the boundary `rx_fill = rx_trig = 64`.
- R3: A high `rx_timeout` with nonzero `rx_fill` and `rx_err` low drives `rx_req_n` low after the next edge, even when `rx_fill` is below `rx_trig`.
- R4: Once `rx_req_n` is low, it stays low while `rx_fill` is nonzero and `rx_err` is low, even when `rx_fill` falls below `rx_trig`.
- R5: `rx_fill` equal to 0 drives `rx_req_n` high after the next edge.
- R6: A high `rx_err` drives `rx_req_n` high after the next edge, whatever the fill level.
- R7: When `tx_free` is greater than or equal to `tx_trig` and `tx_free` is nonzero, `tx_req_n` is low after the next edge.
- R8: Once `tx_req_n` is low, it stays low while `tx_free` is nonzero, even below `tx_trig`. When `tx_free` is 0 (FIFO full), it goes high after the next edge.
- R9: When a raise condition and a release condition coincide, the release wins. For example, a time-out together with an empty receive FIFO, or a full threshold together with `rx_err`, leaves `rx_req_n` high.
- R10: An inactive request stays inactive while its threshold is not met and, for receive, no time-out occurs. Activity on one channel never changes the other channel's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_fill | input | 7 | Receive FIFO fill count, 0 to 64 |
| rx_trig | input | 7 | Receive threshold, 1 to 64 |
| rx_timeout | input | 1 | Receive time-out event |
| rx_err | input | 1 | Receive FIFO holds errored data |
| tx_free | input | 7 | Transmit FIFO free locations, 0 to 64 |
| tx_trig | input | 7 | Transmit threshold, 1 to 64 |
| rx_req_n | output | 1 | Receive DMA request, active low |
| tx_req_n | output | 1 | Transmit DMA request, active low |

## Verification
The fill and free counts are stepped upward across each threshold. This separates a correct greater-or-equal compare from an off-by-one. The counts are then stepped back down below the threshold but not to the limit. This is what separates hysteresis from a plain level compare. Time-out is applied with a count below threshold and again with an empty FIFO, which tests both the alternate raise path and the release-wins priority. The error flag is raised while the request is held and again together with a met threshold. The other channel is watched throughout, to catch any cross-coupling.

// File: rtl/dbh_pkg.sv
package dbh_pkg;
  typedef struct packed {
    logic set;
    logic clr;
  } req_ctl_t;
endpackage

// File: rtl/dbh_rx_cond.sv
module dbh_rx_cond
  import dbh_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] trig,
  input  logic          timeout,
  input  logic          err,
  output req_ctl_t      ctl
);
  always_comb begin
    ctl.set = (fill >= trig) || timeout;
    ctl.clr = (fill == '0) || err;
  end
endmodule

// File: rtl/dbh_tx_cond.sv
module dbh_tx_cond
  import dbh_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic [CW-1:0] free_cnt,
  input  logic [CW-1:0] trig,
  output req_ctl_t      ctl
);
  always_comb begin
    ctl.set = (free_cnt >= trig);
    ctl.clr = (free_cnt == '0);
  end
endmodule

// File: rtl/dbh_req_cell.sv
module dbh_req_cell
  import dbh_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  req_ctl_t ctl,
  output logic     req_n
);
  logic active;
  always_ff @(posedge clk) begin
    if (rst)          active <= 1'b0;
    else if (ctl.clr) active <= 1'b0;
    else if (ctl.set) active <= 1'b1;
  end
  assign req_n = ~active;
endmodule

// File: rtl/dbh_dma_req.sv
module dbh_dma_req #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] rx_fill,
  input  logic [CW-1:0] rx_trig,
  input  logic          rx_timeout,
  input  logic          rx_err,
  input  logic [CW-1:0] tx_free,
  input  logic [CW-1:0] tx_trig,
  output logic          rx_req_n,
  output logic          tx_req_n
);
  import dbh_pkg::*;

  req_ctl_t rx_ctl, tx_ctl;

  dbh_rx_cond #(.CW(CW)) u_rx_cond (
    .fill(rx_fill), .trig(rx_trig), .timeout(rx_timeout), .err(rx_err), .ctl(rx_ctl)
  );

  dbh_tx_cond #(.CW(CW)) u_tx_cond (
    .free_cnt(tx_free), .trig(tx_trig), .ctl(tx_ctl)
  );

  dbh_req_cell u_rx_cell (.clk(clk), .rst(rst), .ctl(rx_ctl), .req_n(rx_req_n));
  dbh_req_cell u_tx_cell (.clk(clk), .rst(rst), .ctl(tx_ctl), .req_n(tx_req_n));
endmodule

// File: rtl/dbh_dma_req_chk.sv
module dbh_dma_req_chk #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] rx_fill,
  input logic [CW-1:0] rx_trig,
  input logic          rx_timeout,
  input logic          rx_err,
  input logic [CW-1:0] tx_free,
  input logic [CW-1:0] tx_trig,
  input logic          rx_req_n,
  input logic          tx_req_n
);
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (rx_req_n && tx_req_n));

  a_r2_rx_threshold: assert property (@(posedge clk) disable iff (rst)
    (rx_fill >= rx_trig && rx_fill != '0 && !rx_err) |=> !rx_req_n);

  a_r3_rx_timeout: assert property (@(posedge clk) disable iff (rst)
    (rx_timeout && rx_fill != '0 && !rx_err) |=> !rx_req_n);

  a_r4_rx_hold: assert property (@(posedge clk) disable iff (rst)
    (!rx_req_n && rx_fill != '0 && !rx_err) |=> !rx_req_n);

  a_r5_rx_empty: assert property (@(posedge clk) disable iff (rst)
    (rx_fill == '0) |=> rx_req_n);

  a_r6_rx_error: assert property (@(posedge clk) disable iff (rst)
    rx_err |=> rx_req_n);

  a_r7_tx_threshold: assert property (@(posedge clk) disable iff (rst)
    (tx_free >= tx_trig && tx_free != '0) |=> !tx_req_n);

  a_r8_tx_full: assert property (@(posedge clk) disable iff (rst)
    (tx_free == '0) |=> tx_req_n);

  a_r8_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (!tx_req_n && tx_free != '0) |=> !tx_req_n);

  a_r10_rx_quiet: assert property (@(posedge clk) disable iff (rst)
    (rx_req_n && rx_fill < rx_trig && !rx_timeout) |=> rx_req_n);

  a_r10_tx_quiet: assert property (@(posedge clk) disable iff (rst)
    (tx_req_n && tx_free < tx_trig) |=> tx_req_n);
endmodule

bind dbh_dma_req dbh_dma_req_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .rx_fill(rx_fill), .rx_trig(rx_trig),
  .rx_timeout(rx_timeout), .rx_err(rx_err), .tx_free(tx_free),
  .tx_trig(tx_trig), .rx_req_n(rx_req_n), .tx_req_n(tx_req_n)
);

// File: tb/sim_dbh_dma_req.sv
`timescale 1ns/1ps
module sim_dbh_dma_req;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] rx_fill = '0, rx_trig = 7'd16, tx_free = '0, tx_trig = 7'd8;
  logic rx_timeout = 1'b0, rx_err = 1'b0;
  logic rx_req_n, tx_req_n;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbh_dma_req u0 (
    .clk(clk), .rst(rst), .rx_fill(rx_fill), .rx_trig(rx_trig),
    .rx_timeout(rx_timeout), .rx_err(rx_err), .tx_free(tx_free),
    .tx_trig(tx_trig), .rx_req_n(rx_req_n), .tx_req_n(tx_req_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rx_drive(input int fill, input int trig, input logic to, input logic er);
    rx_fill = 7'(fill); rx_trig = 7'(trig); rx_timeout = to; rx_err = er;
    step();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    rx_fill = 7'd40; rx_timeout = 1'b1; tx_free = 7'd40;
    step(); step();
    chk("R1 rx reset", rx_req_n, 1'b1);
    chk("R1 tx reset", tx_req_n, 1'b1);
    rx_fill = '0; rx_timeout = 1'b0; tx_free = '0;
    rst = 1'b0;
    step();
  endtask

  task automatic t_rx_threshold_hold();
    rx_drive(15, 16, 0, 0);
    chk("R10 rx below threshold", rx_req_n, 1'b1);
    rx_drive(16, 16, 0, 0);
    chk("R2 rx at threshold", rx_req_n, 1'b0);
    rx_drive(3, 16, 0, 0);
    chk("R4 rx held below threshold", rx_req_n, 1'b0);
    rx_drive(1, 16, 0, 0);
    chk("R4 rx held at one", rx_req_n, 1'b0);
    rx_drive(0, 16, 0, 0);
    chk("R5 rx released at empty", rx_req_n, 1'b1);
    rx_drive(5, 16, 0, 0);
    chk("R10 rx stays idle after release", rx_req_n, 1'b1);
    rx_drive(64, 64, 0, 0);
    chk("R2 rx full boundary", rx_req_n, 1'b0);
    rx_drive(0, 64, 0, 0);
    chk("R5 rx empty again", rx_req_n, 1'b1);
  endtask

  task automatic t_rx_timeout();
    rx_drive(2, 32, 1, 0);
    chk("R3 rx timeout below threshold", rx_req_n, 1'b0);
    rx_drive(2, 32, 0, 0);
    chk("R4 rx held after timeout", rx_req_n, 1'b0);
    rx_drive(0, 32, 0, 0);
    chk("R5 rx release after timeout", rx_req_n, 1'b1);
    rx_drive(0, 32, 1, 0);
    chk("R9 timeout with empty fifo", rx_req_n, 1'b1);
  endtask

  task automatic t_rx_error();
    rx_drive(20, 16, 0, 0);
    chk("R2 rx raise before error", rx_req_n, 1'b0);
    rx_drive(20, 16, 0, 1);
    chk("R6 rx error release", rx_req_n, 1'b1);
    rx_drive(30, 16, 1, 1);
    chk("R9 error beats threshold and timeout", rx_req_n, 1'b1);
    rx_drive(30, 16, 0, 0);
    chk("R2 rx raise after error clears", rx_req_n, 1'b0);
    rx_drive(0, 16, 0, 0);
  endtask

  task automatic t_tx();
    logic rx_before;
    rx_before = rx_req_n;
    tx_trig = 7'd8; tx_free = 7'd7; step();
    chk("R10 tx below threshold", tx_req_n, 1'b1);
    tx_free = 7'd8; step();
    chk("R7 tx at threshold", tx_req_n, 1'b0);
    chk("R10 rx untouched by tx", rx_req_n, rx_before);
    tx_free = 7'd2; step();
    chk("R8 tx held below threshold", tx_req_n, 1'b0);
    tx_free = 7'd0; step();
    chk("R8 tx released at full", tx_req_n, 1'b1);
    tx_free = 7'd5; step();
    chk("R10 tx stays idle after release", tx_req_n, 1'b1);
    tx_trig = 7'd64; tx_free = 7'd64; step();
    chk("R7 tx empty fifo boundary", tx_req_n, 1'b0);
    rx_drive(40, 16, 0, 0);
    chk("R10 tx untouched by rx", tx_req_n, 1'b0);
    tx_free = 7'd0; rx_drive(0, 16, 0, 0);
    chk("R8 tx full again", tx_req_n, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step();
    t_reset();
    t_rx_threshold_hold();
    t_rx_timeout();
    t_rx_error();
    t_tx();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule